// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a variable-length instruction decoder. It accepts the instruction byte stream one byte per cycle on a valid/ready handshake. It takes in the leading prefix bytes of each instruction and sorts each byte into one of four groups:

- lock/repeat
- segment override
- operand size
- address size

It stops at the first byte that is not a prefix and forwards that byte unchanged as the first opcode byte. It does no opcode, addressing-byte or length decoding. The one exception is that it notes whether the opcode begins with the 0FH escape, because that decides whether F2H, F3H or 66H is reported as a mandatory opcode prefix or as an ordinary modifier.

Each instruction produces one registered summary record, held on a valid/ready output. The record carries:

- the group selections
- two branch-hint flags, derived from the segment byte
- the prefix count
- a duplicate-group error flag and a length error flag

The group state clears itself at the end of every record. Downstream logic can therefore present instruction after instruction back to back.

Top module: `pfx_scanner`

## Requirements
- R1: A accepted byte that is not one of the eleven prefix bytes ends the instruction. A record with rec_valid high appears one cycle after the accepting clock edge, carrying that byte on rec_opcode with rec_has_opcode = 1.
- R2: rec_grp1 encodes the lock/repeat group as follows: 0 = none, 1 = F0H, 2 = F2H, 3 = F3H.
- R3: rec_seg encodes the segment override as follows: 0 = none, 1 = 26H, 2 = 2EH, 3 = 36H, 4 = 3EH, 5 = 64H, 6 = 65H.
- R4: rec_hint_not_taken is 1 exactly when the reported segment byte is 2EH. rec_hint_taken is 1 exactly when it is 3EH. The two flags are never both set.
- R5: A 66H prefix sets rec_opsize and a 67H prefix sets rec_adsize. Without those prefixes both flags are 0.
- R6: A second prefix from a group that already holds one sets rec_dup_err. The later byte's value is the one reported for that group.
- R7: When the opcode byte is 0FH, rec_escape is 1, with the following retagging:
  - a held F2H or F3H is reported on rec_mand_f2 or rec_mand_f3, with rec_grp1 = 0;
  - a held 66H is reported on rec_mand_66, with rec_opsize = 0;
  - F0H is unaffected.
  Without the escape, the three mandatory flags are 0.
- R8: rec_count gives the number of prefixes in the instruction. When the MAX_LEN-th prefix (15 by default) is accepted, the record ends at once with rec_len_err = 1, rec_has_opcode = 0 and rec_opcode = 00H. The next byte starts a new instruction.
- R9: in_ready is high whenever no record is held, or whenever the held record is being taken in the same cycle. A held record stays unchanged until rec_ready. No input byte is lost or counted twice under backpressure.
- R10: Synchronous reset clears rec_valid and raises in_ready. Every instruction starts from empty group state, a zero count and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Byte is taken this cycle when in_valid is high |
| rec_valid | output | 1 | Summary record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_grp1 | output | 2 | Lock/repeat selection |
| rec_seg | output | 3 | Segment override selection |
| rec_hint_taken | output | 1 | 3EH seen as segment byte |
| rec_hint_not_taken | output | 1 | 2EH seen as segment byte |
| rec_opsize | output | 1 | Operand-size override as modifier |
| rec_adsize | output | 1 | Address-size override |
| rec_mand_f2 | output | 1 | F2H retagged as mandatory prefix |
| rec_mand_f3 | output | 1 | F3H retagged as mandatory prefix |
| rec_mand_66 | output | 1 | 66H retagged as mandatory prefix |
| rec_escape | output | 1 | Opcode byte is 0FH |
| rec_opcode | output | 8 | First opcode byte, 00H if none |
| rec_has_opcode | output | 1 | Record ended on an opcode byte |
| rec_count | output | $clog2(MAX_LEN+1) | Prefix count |
| rec_dup_err | output | 1 | Two prefixes from one group |
| rec_len_err | output | 1 | Prefix limit reached with no opcode |

## Verification
A prefix byte changes no output. An ending byte, whether an opcode or the limit-reaching prefix, yields a record that is visible on the cycle after its accepting edge. A consumed record drops on the cycle after the edge where rec_ready was high. in_ready follows rec_ready within the same cycle.

The bench drives inputs just after the falling edge and predicts in its model the effect of the coming rising edge. It compares every output at the next falling edge. It checks in_ready one time step after the inputs settle.

Random stalls on rec_ready confirm that held records stay put and that stalled bytes are taken exactly once.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        G1_NONE  = 2'd0,
        G1_LOCK  = 2'd1,
        G1_REPNE = 2'd2,
        G1_REP   = 2'd3
    } g1_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef enum logic [2:0] {
        K_OPCODE = 3'd0,
        K_GRP1   = 3'd1,
        K_SEG    = 3'd2,
        K_OPSZ   = 3'd3,
        K_ADSZ   = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e kind;
        g1_e   g1;
        seg_e  seg;
    } cls_t;

    typedef struct packed {
        g1_e  g1;
        seg_e seg;
        logic opsz;
        logic adsz;
        logic dup;
    } grp_t;

    typedef struct packed {
        g1_e        g1;
        seg_e       seg;
        logic       hint_t;
        logic       hint_nt;
        logic       opsz;
        logic       adsz;
        logic       mand_f2;
        logic       mand_f3;
        logic       mand_66;
        logic       escape;
        logic       has_op;
        logic       dup;
        logic       len_err;
        logic [7:0] opcode;
    } rec_t;

    localparam logic [7:0] ESC_BYTE  = 8'h0F;
    localparam grp_t       GRP_CLEAR = '{g1: G1_NONE, seg: SEG_NONE,
                                         opsz: 1'b0, adsz: 1'b0, dup: 1'b0};

    // Sort one byte into its prefix group (or mark it as an opcode byte).
    function automatic cls_t classify(input logic [7:0] b);
        cls_t c;
        c = '{kind: K_OPCODE, g1: G1_NONE, seg: SEG_NONE};
        case (b)
            8'hF0: begin c.kind = K_GRP1; c.g1  = G1_LOCK;  end
            8'hF2: begin c.kind = K_GRP1; c.g1  = G1_REPNE; end
            8'hF3: begin c.kind = K_GRP1; c.g1  = G1_REP;   end
            8'h26: begin c.kind = K_SEG;  c.seg = SEG_ES;   end
            8'h2E: begin c.kind = K_SEG;  c.seg = SEG_CS;   end
            8'h36: begin c.kind = K_SEG;  c.seg = SEG_SS;   end
            8'h3E: begin c.kind = K_SEG;  c.seg = SEG_DS;   end
            8'h64: begin c.kind = K_SEG;  c.seg = SEG_FS;   end
            8'h65: begin c.kind = K_SEG;  c.seg = SEG_GS;   end
            8'h66: c.kind = K_OPSZ;
            8'h67: c.kind = K_ADSZ;
            default: c.kind = K_OPCODE;
        endcase
        return c;
    endfunction

    // Turn group state plus the ending byte into a summary record.
    function automatic rec_t build_record(input grp_t g, input logic is_op,
                                          input logic [7:0] b);
        rec_t r;
        logic esc;
        esc       = is_op && (b == ESC_BYTE);
        r.g1      = g.g1;
        r.seg     = g.seg;
        r.hint_nt = (g.seg == SEG_CS);
        r.hint_t  = (g.seg == SEG_DS);
        r.adsz    = g.adsz;
        r.mand_f2 = esc && (g.g1 == G1_REPNE);
        r.mand_f3 = esc && (g.g1 == G1_REP);
        r.mand_66 = esc && g.opsz;
        r.opsz    = g.opsz && !esc;
        if (r.mand_f2 || r.mand_f3) r.g1 = G1_NONE;
        r.escape  = esc;
        r.has_op  = is_op;
        r.dup     = g.dup;
        r.len_err = !is_op;
        r.opcode  = is_op ? b : 8'h00;
        return r;
    endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] byte_in,
    output cls_t       cls
);
    always_comb cls = classify(byte_in);
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  cls_t             cls,
    output grp_t             merged,
    output logic [CNT_W-1:0] merged_cnt,
    output logic             end_op,
    output logic             end_len
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_LEN);

    grp_t             st;
    logic [CNT_W-1:0] cnt;
    logic             is_pfx;

    assign is_pfx = (cls.kind != K_OPCODE);

    always_comb begin
        merged     = st;
        merged_cnt = cnt;
        if (accept && is_pfx) begin
            merged_cnt = cnt + 1'b1;
            case (cls.kind)
                K_GRP1: begin
                    if (st.g1 != G1_NONE) merged.dup = 1'b1;
                    merged.g1 = cls.g1;
                end
                K_SEG: begin
                    if (st.seg != SEG_NONE) merged.dup = 1'b1;
                    merged.seg = cls.seg;
                end
                K_OPSZ: begin
                    if (st.opsz) merged.dup = 1'b1;
                    merged.opsz = 1'b1;
                end
                K_ADSZ: begin
                    if (st.adsz) merged.dup = 1'b1;
                    merged.adsz = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign end_op  = accept && !is_pfx;
    assign end_len = accept && is_pfx && (merged_cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || end_op || end_len) begin
            st  <= GRP_CLEAR;
            cnt <= '0;
        end else if (accept) begin
            st  <= merged;
            cnt <= merged_cnt;
        end
    end
endmodule

// File: rtl/pfx_record_reg.sv
module pfx_record_reg
    import pfx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  grp_t             grp,
    input  logic [CNT_W-1:0] cnt,
    input  logic             is_op,
    input  logic [7:0]       byte_in,
    input  logic             take,
    output logic             valid,
    output rec_t             rec,
    output logic [CNT_W-1:0] cnt_q
);
    rec_t nxt;

    always_comb nxt = build_record(grp, is_op, byte_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rec   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            valid <= 1'b1;
            rec   <= nxt;
            cnt_q <= cnt;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pfx_scanner.sv
module pfx_scanner
    import pfx_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [1:0]       rec_grp1,
    output logic [2:0]       rec_seg,
    output logic             rec_hint_taken,
    output logic             rec_hint_not_taken,
    output logic             rec_opsize,
    output logic             rec_adsize,
    output logic             rec_mand_f2,
    output logic             rec_mand_f3,
    output logic             rec_mand_66,
    output logic             rec_escape,
    output logic [7:0]       rec_opcode,
    output logic             rec_has_opcode,
    output logic [CNT_W-1:0] rec_count,
    output logic             rec_dup_err,
    output logic             rec_len_err
);
    cls_t             cls;
    grp_t             merged;
    logic [CNT_W-1:0] merged_cnt;
    logic             end_op, end_len, accept;
    rec_t             rec;

    assign in_ready = !rec_valid || rec_ready;
    assign accept   = in_valid && in_ready;

    pfx_classify u_cls (
        .byte_in (in_byte),
        .cls     (cls)
    );

    pfx_accum #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cls        (cls),
        .merged     (merged),
        .merged_cnt (merged_cnt),
        .end_op     (end_op),
        .end_len    (end_len)
    );

    pfx_record_reg #(.CNT_W(CNT_W)) u_rec (
        .clk     (clk),
        .rst     (rst),
        .load    (end_op || end_len),
        .grp     (merged),
        .cnt     (merged_cnt),
        .is_op   (end_op),
        .byte_in (in_byte),
        .take    (rec_ready),
        .valid   (rec_valid),
        .rec     (rec),
        .cnt_q   (rec_count)
    );

    assign rec_grp1           = rec.g1;
    assign rec_seg            = rec.seg;
    assign rec_hint_taken     = rec.hint_t;
    assign rec_hint_not_taken = rec.hint_nt;
    assign rec_opsize         = rec.opsz;
    assign rec_adsize         = rec.adsz;
    assign rec_mand_f2        = rec.mand_f2;
    assign rec_mand_f3        = rec.mand_f3;
    assign rec_mand_66        = rec.mand_66;
    assign rec_escape         = rec.escape;
    assign rec_opcode         = rec.opcode;
    assign rec_has_opcode     = rec.has_op;
    assign rec_dup_err        = rec.dup;
    assign rec_len_err        = rec.len_err;
endmodule

// File: rtl/pfx_scanner_chk.sv
module pfx_scanner_chk #(
    parameter int MAX_LEN = 15,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [1:0]       rec_grp1,
    input logic [2:0]       rec_seg,
    input logic             rec_hint_taken,
    input logic             rec_hint_not_taken,
    input logic             rec_opsize,
    input logic             rec_mand_f2,
    input logic             rec_mand_f3,
    input logic             rec_mand_66,
    input logic             rec_escape,
    input logic [7:0]       rec_opcode,
    input logic             rec_has_opcode,
    input logic [CNT_W-1:0] rec_count,
    input logic             rec_len_err
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_opcode)
            && $stable(rec_count) && $stable(rec_seg) && $stable(rec_grp1));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |-> !in_ready);

    // R8
    len_err_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_len_err |-> !rec_has_opcode
            && rec_count == CNT_W'(MAX_LEN) && rec_opcode == 8'h00);

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> rec_count <= CNT_W'(MAX_LEN));

    // R1
    opcode_end_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_len_err |-> rec_has_opcode);

    // R4
    hint_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !(rec_hint_taken && rec_hint_not_taken));

    // R7
    esc_tag_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && rec_escape |-> !rec_opsize
            && rec_grp1 != 2'd2 && rec_grp1 != 2'd3);

    // R7
    mand_needs_esc_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && (rec_mand_f2 || rec_mand_f3 || rec_mand_66) |-> rec_escape);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !rec_valid);
endmodule

bind pfx_scanner pfx_scanner_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk                (clk),
    .rst                (rst),
    .in_ready           (in_ready),
    .rec_valid          (rec_valid),
    .rec_ready          (rec_ready),
    .rec_grp1           (rec_grp1),
    .rec_seg            (rec_seg),
    .rec_hint_taken     (rec_hint_taken),
    .rec_hint_not_taken (rec_hint_not_taken),
    .rec_opsize         (rec_opsize),
    .rec_mand_f2        (rec_mand_f2),
    .rec_mand_f3        (rec_mand_f3),
    .rec_mand_66        (rec_mand_66),
    .rec_escape         (rec_escape),
    .rec_opcode         (rec_opcode),
    .rec_has_opcode     (rec_has_opcode),
    .rec_count          (rec_count),
    .rec_len_err        (rec_len_err)
);

// File: tb/tb_pfx_scanner.sv
module tb_pfx_scanner;
    localparam int MAXL = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       rec_ready = 1'b1;
    logic       in_ready, rec_valid;
    logic [1:0] rec_grp1;
    logic [2:0] rec_seg;
    logic       rec_hint_taken, rec_hint_not_taken, rec_opsize, rec_adsize;
    logic       rec_mand_f2, rec_mand_f3, rec_mand_66, rec_escape;
    logic [7:0] rec_opcode;
    logic       rec_has_opcode, rec_dup_err, rec_len_err;
    logic [3:0] rec_count;

    always #4 clk = ~clk;

    pfx_scanner #(.MAX_LEN(MAXL)) dut (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    logic [7:0] q[$];
    int ready_mode = 0;
    int lfsr = 32'h1ACE5;

    // reference model state
    int m_g1, m_seg, m_op, m_ad, m_dup, m_cnt;
    bit e_valid;
    int e_g1, e_seg, e_ht, e_hnt, e_op, e_ad, e_m2, e_m3, e_m66, e_esc;
    int e_opc, e_has, e_cnt, e_dup, e_len;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        m_g1 = 0; m_seg = 0; m_op = 0; m_ad = 0; m_dup = 0; m_cnt = 0;
    endtask

    task automatic emit(bit has, logic [7:0] b);
        bit esc;
        esc   = has && (b == 8'h0F);
        e_m2  = (esc && m_g1 == 2) ? 1 : 0;
        e_m3  = (esc && m_g1 == 3) ? 1 : 0;
        e_g1  = (e_m2 || e_m3) ? 0 : m_g1;
        e_op  = (m_op && !esc) ? 1 : 0;
        e_m66 = (m_op && esc) ? 1 : 0;
        e_seg = m_seg;
        e_hnt = (m_seg == 2) ? 1 : 0;
        e_ht  = (m_seg == 4) ? 1 : 0;
        e_ad  = m_ad;
        e_esc = esc ? 1 : 0;
        e_has = has ? 1 : 0;
        e_opc = has ? int'(b) : 0;
        e_cnt = m_cnt;
        e_dup = m_dup;
        e_len = has ? 0 : 1;
        e_valid = 1;
        clear_model();
    endtask

    task automatic model_byte(logic [7:0] b);
        int g1v = -1, segv = -1;
        bit pre = 1;
        case (b)
            8'hF0: g1v = 1;
            8'hF2: g1v = 2;
            8'hF3: g1v = 3;
            8'h26: segv = 1;
            8'h2E: segv = 2;
            8'h36: segv = 3;
            8'h3E: segv = 4;
            8'h64: segv = 5;
            8'h65: segv = 6;
            8'h66: begin if (m_op) m_dup = 1; m_op = 1; end
            8'h67: begin if (m_ad) m_dup = 1; m_ad = 1; end
            default: pre = 0;
        endcase
        if (g1v >= 0) begin if (m_g1 != 0) m_dup = 1; m_g1 = g1v; end
        if (segv >= 0) begin if (m_seg != 0) m_dup = 1; m_seg = segv; end
        if (pre) begin
            m_cnt++;
            if (m_cnt == MAXL) emit(0, b);
        end else begin
            emit(1, b);
        end
    endtask

    task automatic compare();
        chk("R9 rec_valid", rec_valid, e_valid);
        if (e_valid && rec_valid) begin
            chk("R1 rec_opcode", rec_opcode, e_opc);
            chk("R1 rec_has_opcode", rec_has_opcode, e_has);
            chk("R2 rec_grp1", rec_grp1, e_g1);
            chk("R3 rec_seg", rec_seg, e_seg);
            chk("R4 rec_hint_taken", rec_hint_taken, e_ht);
            chk("R4 rec_hint_not_taken", rec_hint_not_taken, e_hnt);
            chk("R5 rec_opsize", rec_opsize, e_op);
            chk("R5 rec_adsize", rec_adsize, e_ad);
            chk("R6 rec_dup_err", rec_dup_err, e_dup);
            chk("R7 rec_escape", rec_escape, e_esc);
            chk("R7 rec_mand_f2", rec_mand_f2, e_m2);
            chk("R7 rec_mand_f3", rec_mand_f3, e_m3);
            chk("R7 rec_mand_66", rec_mand_66, e_m66);
            chk("R8 rec_count", rec_count, e_cnt);
            chk("R8 rec_len_err", rec_len_err, e_len);
        end
    endtask

    task automatic step();
        bit acc;
        @(negedge clk);
        compare();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
        case (ready_mode)
            0: rec_ready = 1'b1;
            1: rec_ready = lfsr[3] | lfsr[7];
            default: rec_ready = lfsr[5] & lfsr[9];
        endcase
        if (q.size() > 0) begin in_valid = 1'b1; in_byte = q[0]; end
        else begin in_valid = lfsr[11]; in_byte = 8'h90; end
        // idle bytes offered with no queue entry are withdrawn below
        if (q.size() == 0) in_valid = 1'b0;
        #1;
        chk("R9 in_ready", in_ready, (!e_valid || rec_ready) ? 1 : 0);
        acc = in_valid && (!e_valid || rec_ready);
        if (e_valid && rec_ready) e_valid = 0;
        if (acc) begin
            model_byte(q[0]);
            void'(q.pop_front());
        end
        cyc++;
    endtask

    task automatic run(input logic [7:0] bytes[$]);
        foreach (bytes[i]) q.push_back(bytes[i]);
        while (q.size() > 0) step();
        while (e_valid) begin
            step();
            if (ready_mode != 0 && cyc % 7 == 0) ready_mode = ready_mode;
        end
        step();
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v[$];
        clear_model();
        e_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 rec_valid after reset", rec_valid, 0);
        chk("R10 in_ready after reset", in_ready, 1);

        for (int pass = 0; pass < 3; pass++) begin
            ready_mode = pass;
            run('{8'h90});                                   // R1 bare opcode
            run('{8'h66, 8'h0F, 8'h10});                     // R7 mand 66
            run('{8'hF3, 8'h0F, 8'hB8});                     // R7 mand F3
            run('{8'hF2, 8'h0F, 8'h58});                     // R7 mand F2
            run('{8'hF2, 8'hA6});                            // R2 repne, no escape
            run('{8'hF0, 8'h0F, 8'hC1});                     // R7 lock unaffected
            run('{8'h2E, 8'h74});                            // R4 not taken
            run('{8'h3E, 8'h75});                            // R4 taken
            run('{8'h26, 8'h8B});                            // R3 ES
            run('{8'h26, 8'h36, 8'h64, 8'h65, 8'h89});       // R6 segment dup, GS wins
            run('{8'h66, 8'h66, 8'h01});                     // R6 opsize dup
            run('{8'hF0, 8'hF3, 8'hA4});                     // R6 group1 dup, F3 wins
            run('{8'hF0, 8'h67, 8'h66, 8'h2E, 8'h8B});       // R5 all groups
            run('{8'h67, 8'h3E, 8'hF2, 8'h66, 8'h0F, 8'h38});// R7 mixed
            v = {};
            for (int i = 0; i < MAXL; i++) v.push_back((i % 2) ? 8'h66 : 8'h26);
            v.push_back(8'h90);
            run(v);                                          // R8 length limit then new instr
            v = {};
            for (int i = 0; i < MAXL - 1; i++) v.push_back(8'h67);
            v.push_back(8'h0F);
            run(v);                                          // R8 just under limit
            run('{8'h90, 8'h91, 8'h66, 8'h92, 8'h2E, 8'h93}); // R10 back-to-back clears
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule